// File: doc/BRIEF.md
# VLIW bundle executor with previous-value forwarding

This block executes one very-long-instruction bundle per clock for a single work-item lane. A bundle carries five slots, named x, y, z, w and t. Each slot has an integer opcode, a destination register that may be discarded, and two source operands. A source can come from the lane's register file, from one of two per-bundle literals, or from the previous-value (PV) register of any slot. A PV register holds the result that slot produced in the last bundle in which it executed. A compiler can therefore chain dependent operations across bundles without spending a register on each intermediate value. Slots with nothing to do carry a NOP.

The executor has two slot layouts. In five-slot mode, t is the special-function slot and is the only slot allowed to issue the complex operation, the 24-bit multiply. In four-slot mode the t slot is absent, and any of x, y, z, w may issue the multiply. The block reports two kinds of faulty bundle on registered flags: a complex operation in the wrong slot, and two slots writing the same register.

Top module: `vliw_bundle_exec`

## Requirements
- R1: After a synchronous active-low reset, every register and every PV register reads zero and both error flags are low.
- R2: Slot s occupies bundle bits [s*20+19 : s*20], with x=0, y=1, z=2, w=3, t=4. Within a slot, the opcode is at [19:17], the destination enable at [16], the destination at [15:12], source A kind at [11:10], source A index at [9:6], source B kind at [5:4] and source B index at [3:0]. The opcodes are 0 NOP, 1 ADD (wrapping), 2 SHL, 3 SHR (logical), 4 MUL24, 5 MIN (signed), 6 MAX (signed) and 7 NOP. A shift uses only the low 5 bits of B as its amount.
- R3: MUL24 multiplies the low 24 bits of A by the low 24 bits of B, each taken as unsigned, and returns the low 32 bits of the product.
- R4: Source kind 0 reads register [index]. Kind 1 reads PV of slot [index], and an index above 4 reads zero. Kind 2 reads literal lit0 when index bit 0 is 0 and lit1 when it is 1. Kind 3 reads zero.
- R5: Every source in a bundle sees the register and PV values from before that bundle, so two slots can exchange registers within one bundle.
- R6: A slot that executes loads its result into its own PV register at the clock edge. It writes the register file only when its destination enable is 1. With the enable at 0 the result is discarded, and later bundles can reach it only through PV.
- R7: A NOP slot leaves its PV register and the register file unchanged. When bundle_valid is low, every slot acts as a NOP and both error flags are low in the next cycle.
- R8: In five-slot mode, a MUL24 in x, y, z or w is illegal. That slot neither writes nor updates its PV, and err_illegal is high in the next cycle. MUL24 in t executes normally.
- R9: In four-slot mode (mode_five low), the t slot is ignored: PV of t and the registers keep their values whatever t carries. MUL24 executes in any of x, y, z, w.
- R10: When two or more executing slots write the same register, the lowest-numbered slot's value is stored and err_clash is high in the next cycle.
- R11: The error flags are registered. Each is high for the cycle after a bundle that has the condition, and low after a bundle that does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bundle_valid | input | 1 | A bundle is presented this cycle |
| mode_five | input | 1 | 1: five-slot layout with t; 0: four-slot layout |
| bundle | input | 100 | Five 20-bit slot words, x in the low word |
| lit0 | input | 32 | Literal selected by source kind 2, index bit 0 = 0 |
| lit1 | input | 32 | Literal selected by source kind 2, index bit 0 = 1 |
| rd_idx | input | 4 | Register read address for the lane's result port |
| pv_out | output | 160 | PV registers, x in bits [31:0] up to t in [159:128] |
| rd_data | output | 32 | Contents of register rd_idx |
| err_clash | output | 1 | Previous bundle had two writers to one register |
| err_illegal | output | 1 | Previous bundle had a complex op outside t in five-slot mode |

## Verification
A wrong PV register appears on pv_out one cycle after the faulty bundle. It also spreads into the result of any later bundle that forwards from it, so a single bad value is seen twice. A register that is written wrongly or not written at all stays hidden until rd_idx selects it. For this reason the bench sweeps the whole register file after every bundle, and a bad write is caught in the same cycle it lands. A wrong clash or legality decision shows at once on the error flag, and it also shows as a PV or register value that should not have changed.

// File: rtl/vliw_pkg.sv
// Shared encodings for the bundle executor.
// Assumes: fixed opcode and source-kind widths; slot count is five.
package vliw_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int SLOT_T    = 4;
    localparam int OP_W      = 3;
    localparam int KIND_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_SHL   = 3'd2,
        OP_SHR   = 3'd3,
        OP_MUL24 = 3'd4,
        OP_MIN   = 3'd5,
        OP_MAX   = 3'd6,
        OP_RSV   = 3'd7
    } op_e;

    typedef enum logic [KIND_W-1:0] {
        SRC_REG  = 2'd0,
        SRC_PV   = 2'd1,
        SRC_LIT  = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    // True when the opcode performs no work.
    function automatic logic op_is_idle(op_e op);
        return (op == OP_NOP) || (op == OP_RSV);
    endfunction

endpackage

// File: rtl/vliw_regfile.sv
// Lane register file: asynchronous multi-port read, prioritized multi-port write.
// Assumes: write port 0 has the highest priority; reads return pre-edge contents.
module vliw_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int RD_PORTS = 11,
    parameter int WR_PORTS = 5,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RD_PORTS*REG_AW-1:0]   rd_addr,
    output logic [RD_PORTS*DATA_W-1:0]   rd_data,
    input  logic [WR_PORTS-1:0]          wr_en,
    input  logic [WR_PORTS*REG_AW-1:0]   wr_addr,
    input  logic [WR_PORTS*DATA_W-1:0]   wr_data,
    output logic                         clash
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    // Read ports: plain combinational lookup.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data[p*DATA_W +: DATA_W] = mem[rd_addr[p*REG_AW +: REG_AW]];
    end

    // Storage update; ports visited high to low so port 0 lands last and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
        end else begin
            for (int p = WR_PORTS-1; p >= 0; p--) begin
                if (wr_en[p]) mem[wr_addr[p*REG_AW +: REG_AW]] <= wr_data[p*DATA_W +: DATA_W];
            end
        end
    end

    // Detect any pair of enabled write ports aimed at the same register.
    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < WR_PORTS; i++) begin
            for (int j = i + 1; j < WR_PORTS; j++) begin
                if (wr_en[i] && wr_en[j] &&
                    (wr_addr[i*REG_AW +: REG_AW] == wr_addr[j*REG_AW +: REG_AW]))
                    clash = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vliw_operand_mux.sv
// Picks one source operand from register, PV, literal or zero.
// Assumes: the register value was already looked up with the same index.
module vliw_operand_mux
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4
) (
    input  src_e                        kind,
    input  logic [REG_AW-1:0]           idx,
    input  logic [DATA_W-1:0]           reg_val,
    input  logic [NUM_SLOTS*DATA_W-1:0] pv_flat,
    input  logic [DATA_W-1:0]           lit0,
    input  logic [DATA_W-1:0]           lit1,
    output logic [DATA_W-1:0]           val
);

    logic [DATA_W-1:0] pv_pick;

    // Forwarded value of the slot named by idx; unnamed indices give zero.
    always_comb begin
        pv_pick = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (idx == REG_AW'(s)) pv_pick = pv_flat[s*DATA_W +: DATA_W];
        end
    end

    // Final source selection by kind.
    always_comb begin
        unique case (kind)
            SRC_REG:  val = reg_val;
            SRC_PV:   val = pv_pick;
            SRC_LIT:  val = idx[0] ? lit1 : lit0;
            default:  val = '0;
        endcase
    end

endmodule

// File: rtl/vliw_slot_alu.sv
// Integer unit of one slot: add, shifts, narrow multiply, signed min/max.
// Assumes: operands already selected; idle opcodes give zero (result unused).
module vliw_slot_alu
    import vliw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 24,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] a_narrow;
    logic [DATA_W-1:0] b_narrow;
    logic [SH_W-1:0]   shamt;
    logic              a_less;

    assign a_narrow = DATA_W'(a[MUL_W-1:0]);
    assign b_narrow = DATA_W'(b[MUL_W-1:0]);
    assign shamt    = b[SH_W-1:0];
    assign a_less   = $signed(a) < $signed(b);

    // Operation select.
    always_comb begin
        unique case (op)
            OP_ADD:   res = a + b;
            OP_SHL:   res = a << shamt;
            OP_SHR:   res = a >> shamt;
            OP_MUL24: res = a_narrow * b_narrow;
            OP_MIN:   res = a_less ? a : b;
            OP_MAX:   res = a_less ? b : a;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/vliw_bundle_exec.sv
// One-bundle-per-cycle executor for a single lane with per-slot PV forwarding.
// Assumes: all sources are read before any write; lower slot wins a write clash;
// illegal slots are suppressed and flagged; NUM_REGS >= 8 so PV indices fit.
module vliw_bundle_exec
    import vliw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_REGS  = 16,
    parameter int MUL_W     = 24,
    localparam int REG_AW   = $clog2(NUM_REGS),
    localparam int SLOT_W   = 3*REG_AW + 8,
    localparam int BUNDLE_W = NUM_SLOTS*SLOT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bundle_valid,
    input  logic                        mode_five,
    input  logic [BUNDLE_W-1:0]         bundle,
    input  logic [DATA_W-1:0]           lit0,
    input  logic [DATA_W-1:0]           lit1,
    input  logic [REG_AW-1:0]           rd_idx,
    output logic [NUM_SLOTS*DATA_W-1:0] pv_out,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        err_clash,
    output logic                        err_illegal
);

    localparam int B_IDX_LO  = 0;
    localparam int B_KIND_LO = REG_AW;
    localparam int A_IDX_LO  = REG_AW + KIND_W;
    localparam int A_KIND_LO = 2*REG_AW + KIND_W;
    localparam int DST_LO    = 2*REG_AW + 2*KIND_W;
    localparam int DEN_BIT   = 3*REG_AW + 2*KIND_W;
    localparam int OP_LO     = DEN_BIT + 1;
    localparam int RD_PORTS  = 2*NUM_SLOTS + 1;

    logic [RD_PORTS*REG_AW-1:0]  rf_rd_addr;
    logic [RD_PORTS*DATA_W-1:0]  rf_rd_data;
    logic [NUM_SLOTS-1:0]        wr_en;
    logic [NUM_SLOTS*REG_AW-1:0] wr_addr;
    logic [NUM_SLOTS*DATA_W-1:0] wr_data;
    logic                        rf_clash;

    logic [NUM_SLOTS-1:0]        live;
    logic [NUM_SLOTS-1:0]        illegal;
    logic [DATA_W-1:0]           pv_q [NUM_SLOTS];
    logic [NUM_SLOTS*DATA_W-1:0] pv_flat;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int  BASE = s*SLOT_W;
        localparam bit  IS_T = (s == SLOT_T);

        op_e               op;
        src_e              a_kind;
        src_e              b_kind;
        logic [REG_AW-1:0] a_idx;
        logic [REG_AW-1:0] b_idx;
        logic [REG_AW-1:0] dst;
        logic              dst_en;
        logic [DATA_W-1:0] a_val;
        logic [DATA_W-1:0] b_val;
        logic [DATA_W-1:0] res;
        logic              present;

        assign op     = op_e'(bundle[BASE+OP_LO +: OP_W]);
        assign dst_en = bundle[BASE+DEN_BIT];
        assign dst    = bundle[BASE+DST_LO +: REG_AW];
        assign a_kind = src_e'(bundle[BASE+A_KIND_LO +: KIND_W]);
        assign a_idx  = bundle[BASE+A_IDX_LO +: REG_AW];
        assign b_kind = src_e'(bundle[BASE+B_KIND_LO +: KIND_W]);
        assign b_idx  = bundle[BASE+B_IDX_LO +: REG_AW];

        assign rf_rd_addr[(2*s)*REG_AW   +: REG_AW] = a_idx;
        assign rf_rd_addr[(2*s+1)*REG_AW +: REG_AW] = b_idx;

        vliw_operand_mux #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_src_a (
            .kind    (a_kind),
            .idx     (a_idx),
            .reg_val (rf_rd_data[(2*s)*DATA_W +: DATA_W]),
            .pv_flat (pv_flat),
            .lit0    (lit0),
            .lit1    (lit1),
            .val     (a_val)
        );

        vliw_operand_mux #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_src_b (
            .kind    (b_kind),
            .idx     (b_idx),
            .reg_val (rf_rd_data[(2*s+1)*DATA_W +: DATA_W]),
            .pv_flat (pv_flat),
            .lit0    (lit0),
            .lit1    (lit1),
            .val     (b_val)
        );

        vliw_slot_alu #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_alu (
            .op  (op),
            .a   (a_val),
            .b   (b_val),
            .res (res)
        );

        // The t slot exists only in the five-slot layout.
        assign present    = IS_T ? mode_five : 1'b1;
        // Complex op outside t is illegal in the five-slot layout.
        assign illegal[s] = bundle_valid && mode_five && !IS_T && (op == OP_MUL24);
        assign live[s]    = bundle_valid && present && !op_is_idle(op) && !illegal[s];

        assign wr_en[s]                     = live[s] && dst_en;
        assign wr_addr[s*REG_AW +: REG_AW]  = dst;
        assign wr_data[s*DATA_W +: DATA_W]  = res;

        // Previous-value register of this slot: loads only when the slot executes.
        always_ff @(posedge clk) begin
            if (!rst_n)       pv_q[s] <= '0;
            else if (live[s]) pv_q[s] <= res;
        end

        assign pv_flat[s*DATA_W +: DATA_W] = pv_q[s];
    end

    assign rf_rd_addr[(RD_PORTS-1)*REG_AW +: REG_AW] = rd_idx;
    assign rd_data = rf_rd_data[(RD_PORTS-1)*DATA_W +: DATA_W];
    assign pv_out  = pv_flat;

    vliw_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .RD_PORTS (RD_PORTS),
        .WR_PORTS (NUM_SLOTS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rf_rd_addr),
        .rd_data (rf_rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clash   (rf_clash)
    );

    // Error flags, registered once per bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_clash   <= 1'b0;
            err_illegal <= 1'b0;
        end else begin
            err_clash   <= bundle_valid && rf_clash;
            err_illegal <= |illegal;
        end
    end

endmodule

// File: rtl/vliw_bundle_exec_chk.sv
// Property checker for the bundle executor, attached by bind.
// Assumes: slot field layout as in the top module.
module vliw_bundle_exec_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int SLOT_W  = 3*REG_AW + 8,
    localparam int NSL     = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bundle_valid,
    input logic                  mode_five,
    input logic [NSL*SLOT_W-1:0] bundle,
    input logic [DATA_W-1:0]     lit0,
    input logic [DATA_W-1:0]     lit1,
    input logic [NSL*DATA_W-1:0] pv_out,
    input logic                  err_clash,
    input logic                  err_illegal
);

    localparam int OP_LO = 3*REG_AW + 5;
    localparam int AK_LO = 2*REG_AW + 2;
    localparam int AI_LO = REG_AW + 2;
    localparam int BK_LO = REG_AW;

    logic [2:0]        x_op;
    logic              x_add_lits;
    logic [DATA_W-1:0] pv_x;
    logic [DATA_W-1:0] pv_t;

    assign x_op       = bundle[OP_LO +: 3];
    assign x_add_lits = (x_op == 3'd1) &&
                        (bundle[AK_LO +: 2] == 2'd2) && !bundle[AI_LO] &&
                        (bundle[BK_LO +: 2] == 2'd2) && bundle[0];
    assign pv_x = pv_out[0 +: DATA_W];
    assign pv_t = pv_out[4*DATA_W +: DATA_W];

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bundle_valid |=> ($stable(pv_out) && !err_clash && !err_illegal));

    a_r9_t_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_valid && !mode_five) |=> $stable(pv_t));

    a_r8_illegal_needs_five: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> $past(bundle_valid && mode_five));

    a_r8_x_mul_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_valid && mode_five && x_op == 3'd4) |=> ($stable(pv_x) && err_illegal));

    a_r10_clash_needs_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        err_clash |-> $past(bundle_valid));

    a_r4_x_literal_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_valid && x_add_lits) |=> (pv_x == $past(lit0 + lit1)));

endmodule

bind vliw_bundle_exec vliw_bundle_exec_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bundle_valid (bundle_valid),
    .mode_five    (mode_five),
    .bundle       (bundle),
    .lit0         (lit0),
    .lit1         (lit1),
    .pv_out       (pv_out),
    .err_clash    (err_clash),
    .err_illegal  (err_illegal)
);

// File: tb/sim_vliw_bundle_exec.sv
`timescale 1ns/1ps
// Bench: behavioural lane model updated per bundle, compared after every edge.
module sim_vliw_bundle_exec;

    localparam real CLK_PERIOD = 20.0;
    localparam int  NREG = 16;
    localparam int  SW   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bundle_valid = 1'b0;
    logic          mode_five = 1'b1;
    logic [5*SW-1:0] bundle = '0;
    logic [31:0]   lit0 = '0;
    logic [31:0]   lit1 = '0;
    logic [3:0]    rd_idx = '0;
    logic [159:0]  pv_out;
    logic [31:0]   rd_data;
    logic          err_clash;
    logic          err_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_reg [NREG];
    logic [31:0] m_pv  [5];
    logic        m_clash;
    logic        m_illegal;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_bundle_exec u0 (
        .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid), .mode_five(mode_five),
        .bundle(bundle), .lit0(lit0), .lit1(lit1), .rd_idx(rd_idx),
        .pv_out(pv_out), .rd_data(rd_data), .err_clash(err_clash), .err_illegal(err_illegal)
    );

    function automatic logic [SW-1:0] slot(int op, int den, int dst, int ak, int ai, int bk, int bi);
        return {3'(op), 1'(den), 4'(dst), 2'(ak), 4'(ai), 2'(bk), 4'(bi)};
    endfunction

    function automatic logic [31:0] src(int kind, int idx, logic [31:0] l0, logic [31:0] l1);
        if (kind == 0) return m_reg[idx];
        if (kind == 1) return (idx < 5) ? m_pv[idx] : 32'd0;
        if (kind == 2) return (idx % 2 == 1) ? l1 : l0;
        return 32'd0;
    endfunction

    function automatic logic [31:0] calc(int op, logic [31:0] a, logic [31:0] b);
        longint unsigned p;
        int sa, sb;
        sa = int'(a); sb = int'(b);
        case (op)
            1: return a + b;
            2: return a << (b % 32);
            3: return a >> (b % 32);
            4: begin p = longint'(a % 32'h0100_0000) * longint'(b % 32'h0100_0000); return p[31:0]; end
            5: return (sa < sb) ? a : b;
            6: return (sa > sb) ? a : b;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every port-visible piece of state with the model.
    task automatic compare(string req);
        for (int s = 0; s < 5; s++) chk(req, $sformatf("pv[%0d]", s), pv_out[s*32 +: 32], m_pv[s]);
        chk(req, "err_clash (R11)", 32'(err_clash), 32'(m_clash));
        chk(req, "err_illegal (R11)", 32'(err_illegal), 32'(m_illegal));
        for (int r = 0; r < NREG; r++) begin
            rd_idx = 4'(r);
            #0.5;
            chk(req, $sformatf("reg[%0d]", r), rd_data, m_reg[r]);
        end
    endtask

    // Drive one bundle, advance the model, compare after the edge.
    task automatic issue(bit v, bit five, logic [5*SW-1:0] b, logic [31:0] l0, logic [31:0] l1, string req);
        logic [31:0] res [5];
        bit          run [5];
        int          wcnt [NREG];
        @(negedge clk);
        bundle_valid = v; mode_five = five; bundle = b; lit0 = l0; lit1 = l1;
        m_clash = 0; m_illegal = 0;
        for (int r = 0; r < NREG; r++) wcnt[r] = 0;
        for (int s = 0; s < 5; s++) begin
            logic [SW-1:0] w;
            int op;
            w  = b[s*SW +: SW];
            op = int'(w[19:17]);
            res[s] = calc(op, src(int'(w[11:10]), int'(w[9:6]), l0, l1),
                              src(int'(w[5:4]),   int'(w[3:0]), l0, l1));
            run[s] = v && (op != 0) && (op != 7) && (s != 4 || five);
            if (v && five && s != 4 && op == 4) begin run[s] = 0; m_illegal = 1; end
            if (run[s] && w[16]) wcnt[int'(w[15:12])]++;
        end
        for (int r = 0; r < NREG; r++) if (wcnt[r] > 1) m_clash = 1;
        for (int s = 4; s >= 0; s--) begin
            if (run[s]) begin
                m_pv[s] = res[s];
                if (b[s*SW+16]) m_reg[int'(b[s*SW+12 +: 4])] = res[s];
            end
        end
        @(posedge clk);
        #1;
        compare(req);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5*SW-1:0] b;
        for (int r = 0; r < NREG; r++) m_reg[r] = '0;
        for (int s = 0; s < 5; s++) m_pv[s] = '0;
        m_clash = 0; m_illegal = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1; compare("R1");

        // R2/R4: load registers from literals and zero source.
        b = '0;
        b[0*SW +: SW] = slot(1, 1, 1, 2, 0, 3, 0);
        b[1*SW +: SW] = slot(1, 1, 0, 2, 1, 3, 0);
        issue(1, 1, b, 32'd5, 32'd7, "R4");

        // R6: dependency chain through discarded PV results.
        b = '0; b[1*SW +: SW] = slot(2, 0, 0, 0, 1, 2, 0);
        issue(1, 1, b, 32'd8, 32'd0, "R6");
        b = '0; b[3*SW +: SW] = slot(1, 0, 0, 0, 0, 1, 1);
        issue(1, 1, b, 32'd0, 32'd0, "R6");
        b = '0; b[2*SW +: SW] = slot(2, 0, 0, 1, 3, 2, 0);
        issue(1, 1, b, 32'd2, 32'd0, "R6");
        b = '0; b[0*SW +: SW] = slot(3, 1, 2, 1, 2, 2, 0);
        issue(1, 1, b, 32'd2, 32'd0, "R6");

        // R2: signed min/max, shift amount above 31, wrapping add.
        b = '0;
        b[0*SW +: SW] = slot(5, 1, 3, 2, 0, 2, 1);
        b[1*SW +: SW] = slot(6, 1, 4, 2, 0, 2, 1);
        b[2*SW +: SW] = slot(3, 1, 5, 2, 0, 2, 1);
        b[3*SW +: SW] = slot(1, 1, 6, 2, 0, 2, 0);
        b[4*SW +: SW] = slot(2, 1, 7, 2, 0, 2, 1);
        issue(1, 1, b, 32'hFFFF_FFF0, 32'd33, "R2");

        // R3: MUL24 in t with high bits set on both operands.
        b = '0; b[4*SW +: SW] = slot(4, 1, 8, 2, 0, 2, 1);
        issue(1, 1, b, 32'h0100_0003, 32'hFF00_0005, "R3");
        b = '0; b[4*SW +: SW] = slot(4, 1, 9, 2, 0, 2, 1);
        issue(1, 1, b, 32'h00FF_FFFF, 32'h00FF_FFFF, "R3");

        // R8: MUL24 in x under five-slot mode is suppressed and flagged.
        b = '0; b[0*SW +: SW] = slot(4, 1, 10, 2, 0, 2, 1);
        b[1*SW +: SW] = slot(1, 1, 11, 2, 0, 2, 1);
        issue(1, 1, b, 32'd6, 32'd9, "R8");

        // R9: four-slot mode, MUL24 in y, t slot ignored.
        b = '0; b[1*SW +: SW] = slot(4, 1, 10, 2, 0, 2, 1);
        b[4*SW +: SW] = slot(1, 1, 12, 2, 0, 2, 1);
        issue(1, 0, b, 32'd6, 32'd9, "R9");

        // R10: x and z write the same register, x wins.
        b = '0; b[0*SW +: SW] = slot(1, 1, 5, 2, 0, 3, 0);
        b[2*SW +: SW] = slot(1, 1, 5, 2, 1, 3, 0);
        issue(1, 1, b, 32'hAAAA_0001, 32'hBBBB_0002, "R10");
        // R11: flags drop after a clean bundle.
        b = '0; b[0*SW +: SW] = slot(1, 1, 13, 2, 0, 3, 0);
        issue(1, 1, b, 32'd3, 32'd0, "R11");

        // R5: registers 1 and 2 exchange within one bundle.
        b = '0; b[0*SW +: SW] = slot(1, 1, 1, 0, 2, 3, 0);
        b[1*SW +: SW] = slot(1, 1, 2, 0, 1, 3, 0);
        issue(1, 1, b, 32'd0, 32'd0, "R5");

        // R7: NOP encodings with destination enabled, then an idle cycle.
        b = '0; b[0*SW +: SW] = slot(7, 1, 1, 2, 0, 2, 0);
        b[1*SW +: SW] = slot(0, 1, 2, 2, 0, 2, 0);
        issue(1, 1, b, 32'hDEAD_BEEF, 32'd1, "R7");
        b = '0; b[0*SW +: SW] = slot(4, 1, 1, 2, 0, 2, 0);
        issue(0, 1, b, 32'hDEAD_BEEF, 32'd1, "R7");

        // R4: PV index above 4 and kind 3 read zero.
        b = '0; b[0*SW +: SW] = slot(1, 1, 14, 1, 6, 3, 9);
        b[1*SW +: SW] = slot(1, 1, 15, 1, 4, 1, 0);
        issue(1, 1, b, 32'd0, 32'd0, "R4");

        // R2/R8/R9/R10: mixed random bundles.
        for (int n = 0; n < 400; n++) begin
            for (int s = 0; s < 5; s++)
                b[s*SW +: SW] = slot($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 15),
                                     $urandom_range(0, 3), $urandom_range(0, 15),
                                     $urandom_range(0, 3), $urandom_range(0, 15));
            issue($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, b, $urandom, $urandom, "R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule